// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block sets the length of the high-voltage pulse used to program or erase a non-volatile memory array. It then times the recovery interval that has to pass, once the voltage is removed, before the array may change mode. A rising edge on the high-voltage request starts an operation. At that edge the block captures four control values: the clock range code, the exponent adjust, the multiplier and the erase/program selector. It holds them for the whole operation.

The pulse lasts R x 2^N x M system clocks, where:
- R is the scaling factor selected by the range code.
- N is the exponent. In erase mode it is larger.
- M is the multiplier.

Recovery lasts 48 scaled clock periods. When the range code is zero, recovery lasts 128 plain system clocks instead. A status flag is high from the first pulse cycle until recovery is over. A separate flag marks the recovery phase, and a one-cycle done strobe marks the end of recovery.

Top module: `pe_pulse_timer`

## Requirements
- R1: During and immediately after reset, `hv_active`, `recov_busy` and `done` are all 0.
- R2: The range code `range_sel` selects the scale factor R = `range_sel` + 1, so code 0 gives 1 and code 7 gives 8.
- R3: The exponent is N = 5 + `exp_adj`, plus a further 10 when `erase_mode` is 1.
- R4: The multiplier is M = `mult` + 1, which ranges from 1 to 128.
- R5: Without an early abort, `hv_active` is high and `recov_busy` is low for exactly R x 2^N x M cycles, starting one clock after the rising edge of `hv_req` is sampled.
- R6: When the captured range code is nonzero, `recov_busy` stays high for exactly 48 x R cycles directly after the pulse.
- R7: When the captured range code is 0, `recov_busy` stays high for exactly 128 cycles.
- R8: `hv_active` stays high continuously from the first pulse cycle through the last recovery cycle. `recov_busy` is only ever high while `hv_active` is high.
- R9: `done` is high for exactly one cycle. That cycle is the first cycle after recovery, in which `hv_active` and `recov_busy` are both 0.
- R10: If `hv_req` is sampled low during the pulse, the pulse ends and recovery begins on the next cycle. Recovery then runs its full length.
- R11: Changes to `range_sel`, `exp_adj`, `mult` or `erase_mode` after the start edge have no effect on the running operation.
- R12: A rising edge of `hv_req` while the block is busy is ignored. If `hv_req` is still high when the block returns to idle, no new operation starts until `hv_req` has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 3 | Clock range code; scale factor is code + 1 |
| exp_adj | input | 2 | Added to the base exponent of 5 |
| mult | input | 7 | Multiplier minus one |
| erase_mode | input | 1 | 1 = erase (exponent + 10), 0 = program |
| hv_req | input | 1 | High-voltage request; a rising edge starts an operation, and a low level aborts a pulse |
| hv_active | output | 1 | High from pulse start until recovery ends |
| recov_busy | output | 1 | High during the recovery interval |
| done | output | 1 | One-cycle strobe when recovery ends |

## Verification
The embedded assertions check the following on every cycle:
- `recov_busy` never appears without `hv_active`.
- Recovery can only be left through a single-cycle `done`.
- An abort leads straight into recovery.
- The captured parameters stay constant while busy.
- The prescale, pulse and recovery counters never pass their limits.

Only the bench scenarios can show that the pulse and recovery lengths equal the products the formula gives for each code. The same holds for proving that parameters changed mid-operation and retriggers during recovery really leave the timing untouched.

// File: rtl/pe_timer_pkg.sv
package pe_timer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RECOV = 2'd2
  } pe_state_t;

  // Base exponent and erase increment of the binary pulse counter
  localparam int unsigned EXP_BASE  = 5;
  localparam int unsigned ERASE_EXP = 10;
  // Recovery lengths in scaled ticks
  localparam int unsigned REC_SCALED = 48;
  localparam int unsigned REC_RAW    = 128;

endpackage

// File: rtl/pe_prescaler.sv
module pe_prescaler #(
  parameter int RANGE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               restart,
  input  logic [RANGE_W-1:0] div_m1,
  output logic               tick
);

  logic [RANGE_W-1:0] presc_q;

  assign tick = run && (presc_q == div_m1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      presc_q <= '0;
    end else if (presc_q == div_m1) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  // R2: the divider phase never exceeds the selected factor minus one
  a_r2_presc_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (presc_q <= div_m1));

endmodule

// File: rtl/pe_pulse_counter.sv
module pe_pulse_counter #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = tick && (cnt_q == term - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the tick count stays below the pulse length in ticks
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt_q < term));

endmodule

// File: rtl/pe_recovery_counter.sv
module pe_recovery_counter #(
  parameter int REC_SCALED = 48,
  parameter int REC_RAW    = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic raw_mode,
  output logic last
);

  localparam int REC_MAX = (REC_SCALED > REC_RAW) ? REC_SCALED : REC_RAW;
  localparam int REC_W   = $clog2(REC_MAX + 1);

  logic [REC_W-1:0] cnt_q;
  logic [REC_W-1:0] limit;

  assign limit = raw_mode ? REC_W'(REC_RAW) : REC_W'(REC_SCALED);
  assign last  = tick && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6 / R7: recovery count never passes its selected limit
  a_r6_rec_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/pe_pulse_timer.sv
module pe_pulse_timer
  import pe_timer_pkg::*;
#(
  parameter int RANGE_W = 3,
  parameter int ADJ_W   = 2,
  parameter int MULT_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RANGE_W-1:0] range_sel,
  input  logic [ADJ_W-1:0]   exp_adj,
  input  logic [MULT_W-1:0]  mult,
  input  logic               erase_mode,
  input  logic               hv_req,
  output logic               hv_active,
  output logic               recov_busy,
  output logic               done
);

  localparam int MAX_N  = EXP_BASE + (2**ADJ_W - 1) + ERASE_EXP;
  localparam int CNT_W  = MULT_W + 1 + MAX_N + 1;
  localparam int EXP_W  = $clog2(MAX_N + 1);

  pe_state_t st_q, st_n;
  logic               req_q;
  logic [RANGE_W-1:0] rng_q;
  logic [ADJ_W-1:0]   adj_q;
  logic [MULT_W-1:0]  mul_q;
  logic               ers_q;

  logic start, pulse_end, rec_end;
  logic tick, p_last, r_last;
  logic [EXP_W-1:0] n_exp;
  logic [CNT_W-1:0] term;

  // Pulse length in scaled ticks: (mult+1) << N
  always_comb begin
    n_exp = EXP_W'(EXP_BASE) + EXP_W'(adj_q) + (ers_q ? EXP_W'(ERASE_EXP) : '0);
    term  = (CNT_W'(mul_q) + 1'b1) << n_exp;
  end

  always_comb begin
    start     = (st_q == ST_IDLE) && hv_req && !req_q;
    pulse_end = (st_q == ST_PULSE) && (p_last || !hv_req);
    rec_end   = (st_q == ST_RECOV) && r_last;
    st_n      = st_q;
    case (st_q)
      ST_IDLE:  if (start)     st_n = ST_PULSE;
      ST_PULSE: if (pulse_end) st_n = ST_RECOV;
      ST_RECOV: if (rec_end)   st_n = ST_IDLE;
      default:                 st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      req_q      <= 1'b0;
      rng_q      <= '0;
      adj_q      <= '0;
      mul_q      <= '0;
      ers_q      <= 1'b0;
      hv_active  <= 1'b0;
      recov_busy <= 1'b0;
      done       <= 1'b0;
    end else begin
      st_q       <= st_n;
      req_q      <= hv_req;
      hv_active  <= (st_n != ST_IDLE);
      recov_busy <= (st_n == ST_RECOV);
      done       <= rec_end;
      if (start) begin
        rng_q <= range_sel;
        adj_q <= exp_adj;
        mul_q <= mult;
        ers_q <= erase_mode;
      end
    end
  end

  pe_prescaler #(.RANGE_W(RANGE_W)) i_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q != ST_IDLE),
    .restart (st_n != st_q),
    .div_m1  (rng_q),
    .tick    (tick)
  );

  pe_pulse_counter #(.CNT_W(CNT_W)) i_pulse (
    .clk   (clk),
    .rst   (rst),
    .clear ((st_q != ST_PULSE) || pulse_end),
    .tick  (tick),
    .term  (term),
    .last  (p_last)
  );

  pe_recovery_counter #(
    .REC_SCALED (REC_SCALED),
    .REC_RAW    (REC_RAW)
  ) i_recov (
    .clk      (clk),
    .rst      (rst),
    .run      (st_q == ST_RECOV),
    .tick     (tick),
    .raw_mode (rng_q == '0),
    .last     (r_last)
  );

  // R8: recovery flag only within the high-voltage window
  a_r8_busy_inside_hv: assert property (@(posedge clk) disable iff (rst)
    recov_busy |-> hv_active);

  // R9: done lasts one cycle and follows recovery with outputs idle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_after_recov: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(recov_busy) && !hv_active && !recov_busy));
  a_r9_recov_exit: assert property (@(posedge clk) disable iff (rst)
    recov_busy |=> (recov_busy || done));

  // R10: an early drop of the request enters recovery next cycle
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (hv_active && !recov_busy && !hv_req) |=> recov_busy);

  // R11: captured parameters stay fixed while busy
  a_r11_hold_params: assert property (@(posedge clk) disable iff (rst)
    (hv_active && $past(hv_active)) |->
      ($stable(rng_q) && $stable(adj_q) && $stable(mul_q) && $stable(ers_q)));

endmodule

// File: tb/test_pe_pulse_timer.sv
module test_pe_pulse_timer;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] range_sel;
  logic [1:0] exp_adj;
  logic [6:0] mult;
  logic       erase_mode;
  logic       hv_req;
  logic       hv_active, recov_busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pe_pulse_timer i_pe_pulse_timer (
    .clk(clk), .rst(rst), .range_sel(range_sel), .exp_adj(exp_adj),
    .mult(mult), .erase_mode(erase_mode), .hv_req(hv_req),
    .hv_active(hv_active), .recov_busy(recov_busy), .done(done)
  );

  function automatic int exp_pulse(int rng, int adj, int mul, int ers);
    int n;
    n = 5 + adj + (ers != 0 ? 10 : 0);
    return (rng + 1) * (1 << n) * (mul + 1);
  endfunction

  function automatic int exp_rec(int rng);
    return (rng == 0) ? 128 : 48 * (rng + 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_op(int rng, int adj, int mul, int ers, int abort_at,
                        bit scramble, bit retrig);
    int pc, rc, pexp;
    pexp = (abort_at != 0) ? abort_at : exp_pulse(rng, adj, mul, ers);
    @(negedge clk);
    range_sel = 3'(rng); exp_adj = 2'(adj); mult = 7'(mul); erase_mode = ers[0];
    hv_req = 1'b1;
    @(negedge clk);
    check(hv_active && !recov_busy, "R8 pulse start", {hv_active, recov_busy}, 2);
    if (scramble) begin
      range_sel = 3'($urandom); exp_adj = 2'($urandom);
      mult = 7'($urandom); erase_mode = 1'($urandom);
    end
    pc = 1;
    while (1) begin
      if (abort_at != 0 && pc == abort_at) hv_req = 1'b0;
      @(negedge clk);
      if (recov_busy || !hv_active || pc > 70000) break;
      pc++;
    end
    check(pc == pexp, (abort_at != 0) ? "R10 abort pulse length" :
          (scramble ? "R11 R2 R3 R4 R5 pulse length" : "R2 R3 R4 R5 pulse length"),
          pc, pexp);
    check(hv_active, "R8 hv at recovery", hv_active, 1);
    rc = 1;
    while (1) begin
      if (retrig && rc == 2) hv_req = 1'b0;
      if (retrig && rc == 4) hv_req = 1'b1;
      @(negedge clk);
      if (!recov_busy || rc > 1000) break;
      check(hv_active, "R8 hv during recovery", hv_active, 1);
      rc++;
    end
    check(rc == exp_rec(rng), (rng == 0) ? "R7 raw recovery" : "R6 scaled recovery",
          rc, exp_rec(rng));
    check(done && !hv_active, "R9 done at end", {done, hv_active}, 2);
    @(negedge clk);
    check(!done, "R9 done width", done, 0);
    if (hv_req) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        check(!hv_active, "R12 no restart while held", hv_active, 0);
      end
    end
    hv_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; hv_req = 1'b0; range_sel = '0; exp_adj = '0; mult = '0; erase_mode = 1'b0;
    repeat (3) @(negedge clk);
    check(!hv_active && !recov_busy && !done, "R1 in reset", {hv_active, recov_busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!hv_active && !recov_busy && !done, "R1 after reset", {hv_active, recov_busy, done}, 0);

    run_op(0, 0, 0, 0, 0, 0, 0);      // R7 minimum program pulse, raw recovery
    run_op(7, 0, 0, 0, 0, 0, 0);      // R2 max scale, R6 recovery 384
    run_op(0, 0, 127, 0, 0, 0, 0);    // R4 max multiplier
    run_op(1, 3, 0, 0, 0, 0, 0);      // R3 max adjust
    run_op(0, 0, 0, 1, 0, 0, 0);      // R3 erase exponent
    run_op(2, 1, 3, 0, 37, 0, 0);     // R10 abort
    run_op(3, 0, 1, 0, 0, 1, 0);      // R11 scramble
    run_op(1, 0, 0, 0, 0, 0, 1);      // R12 retrigger during recovery
    run_op(0, 1, 2, 0, 5, 0, 1);      // R10 + R12

    for (int k = 0; k < 20; k++) begin
      int r, a, m, ab;
      r  = $urandom_range(0, 7);
      a  = $urandom_range(0, 1);
      m  = $urandom_range(0, 3);
      ab = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 20) : 0;
      run_op(r, a, m, 0, ab, k[0], k[1]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule